// File: doc/BRIEF.md
# Flash protection-erase command sequencer

This block sits between a CPU write/read bus and a small flash array model. It watches bus writes for a seven-cycle command. When the full command arrives, it launches an automatic operation. That operation first wipes every data block of the array to all-ones. Then, one slot at a time, it clears the protection bits picked by the final write. The order of the slots is fixed. While the operation runs, the ready flag sits at 0. It returns to 1 on its own when the last slot ends, and the block is then back in read mode.

New command writes are ignored while the operation runs, and so is the software reset request. Only the hardware reset `rst_ni` stops the operation. Array contents and protection bits are nonvolatile, so a hardware reset does not touch them. Only the power-on reset `por_ni` reloads them, which lets an interrupted erase be seen afterwards. Reads that come from outside the flash region return zero and are flagged as blocked while every protection bit is set. Nothing verifies the erase: software reads back the array to confirm it.

Top module: `flash_prot_erase_seq`

## Requirements
- R1: After `por_ni` and `rst_ni`, `rdy_o` is 1 and `prot_o` is all ones. Block k of the array reads 0x1000+k.
- R2: The command is seven writes in this order, as (address, data): (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x60), then a write to any address whose data bits [NPROT-1:0] form the target mask. `rdy_o` reads 0 from the cycle after the seventh write.
- R3: A write in cycles 1 to 6 whose address or data differs from the expected value returns the cycle counter to zero. A run of the remaining correct writes then starts nothing.
- R4: Bus writes made while `rdy_o` is 0 are ignored and do not advance the cycle counter.
- R5: When idle, `sw_rst_i` returns the cycle counter to zero, and it wins over a write in the same cycle. While busy, it has no effect on the operation or its length.
- R6: Block k reads all ones from BLK_CYC*(k+1) cycles after the seventh write. Every block is erased before any protection bit changes.
- R7: Protection bit i is cleared NBLK*BLK_CYC + PROT_CYC*(i+1) cycles after the seventh write if mask bit i is 1. It is left unchanged if mask bit i is 0. Protection bits never go from 0 to 1 except by `por_ni`.
- R8: `rdy_o` returns to 1 exactly NBLK*BLK_CYC + NPROT*PROT_CYC cycles after the seventh write, with no further command.
- R9: Asserting `rst_ni` during the operation forces `rdy_o` to 1 and zeroes the cycle counter. It keeps the array and protection bits in the partial state reached.
- R10: While every protection bit is 1, a read with `rd_ext_i`=1 gives `rd_blocked_o`=1 and data 0. Otherwise `rd_data_o` is the addressed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous; resets sequencer only |
| por_ni | input | 1 | Power-on reset, active low; reloads array and protection bits |
| bus_wr_i | input | 1 | Bus write strobe, one write per high cycle |
| bus_addr_i | input | 12 | Bus write address |
| bus_wdata_i | input | 16 | Bus write data |
| sw_rst_i | input | 1 | Software reset request |
| rd_addr_i | input | $clog2(NBLK) | Block index to read |
| rd_ext_i | input | 1 | Read originates outside the flash region |
| rd_data_o | output | 16 | Read data |
| rd_blocked_o | output | 1 | Read refused by protection |
| rdy_o | output | 1 | 1 in read mode, 0 during the automatic operation |
| prot_o | output | NPROT | Protection bit status |

## Verification
The assertions assume that `por_ni` is applied before any command, so protection bits start from a defined value. They also assume that `rst_ni` is released only when no write is pending. Protection bits may fall only while busy. Apart from the power-on reset, they never rise. A stretch of busy cycles ends only after the full count, unless a hardware reset cuts it short. The stimulus drives every input at the falling clock edge and applies `por_ni` at the start of each mask iteration. It raises hardware reset only at a falling edge, with no write in flight.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int CMD_LEN = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PROT} eng_state_e;

  // expected address of unlock cycle c (1..6)
  function automatic logic [ADDR_W-1:0] cmd_addr(input int c);
    case (c)
      2, 5:    return ADDR_W'('h2AA);
      default: return ADDR_W'('h555);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] cmd_data(input int c);
    case (c)
      1, 4:    return DATA_W'('hAA);
      2, 5:    return DATA_W'('h55);
      3:       return DATA_W'('h80);
      default: return DATA_W'('h60);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] init_word(input int k);
    return DATA_W'('h1000 + k);
  endfunction
endpackage

// File: rtl/fps_cmd_decode.sv
module fps_cmd_decode
  import flash_seq_pkg::*;
#(
  parameter int NPROT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sw_rst_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic [NPROT-1:0]  mask_o,
  output logic [2:0]        cnt_o
);
  logic [2:0] cnt_q;
  logic       hit;

  assign hit     = (addr_i == cmd_addr(int'(cnt_q) + 1)) &&
                   (wdata_i == cmd_data(int'(cnt_q) + 1));
  assign start_o = wr_i && !busy_i && !sw_rst_i && (cnt_q == 3'(CMD_LEN - 1));
  assign mask_o  = wdata_i[NPROT-1:0];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (busy_i)   cnt_q <= cnt_q;
    else if (sw_rst_i) cnt_q <= '0;
    else if (wr_i) begin
      if (cnt_q == 3'(CMD_LEN - 1)) cnt_q <= '0;
      else if (hit)                 cnt_q <= cnt_q + 3'd1;
      else                          cnt_q <= '0;
    end
  end
endmodule

// File: rtl/fps_erase_engine.sv
module fps_erase_engine
  import flash_seq_pkg::*;
#(
  parameter int NBLK     = 4,
  parameter int NPROT    = 4,
  parameter int BLK_CYC  = 3,
  parameter int PROT_CYC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NPROT-1:0]         mask_i,
  output logic                     busy_o,
  output logic                     blk_clr_o,
  output logic [$clog2(NBLK)-1:0]  blk_idx_o,
  output logic                     prot_clr_o,
  output logic [$clog2(NPROT)-1:0] prot_idx_o
);
  localparam int MAXC = (BLK_CYC > PROT_CYC) ? BLK_CYC : PROT_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int BIW  = $clog2(NBLK);
  localparam int PIW  = $clog2(NPROT);

  eng_state_e       st_q;
  logic [TW-1:0]    tmr_q;
  logic [BIW-1:0]   bidx_q;
  logic [PIW-1:0]   pidx_q;
  logic [NPROT-1:0] mask_q;
  logic             blk_end, prot_end;

  assign blk_end    = (st_q == ST_DATA) && (tmr_q == TW'(BLK_CYC - 1));
  assign prot_end   = (st_q == ST_PROT) && (tmr_q == TW'(PROT_CYC - 1));
  assign busy_o     = (st_q != ST_IDLE);
  assign blk_clr_o  = blk_end;
  assign blk_idx_o  = bidx_q;
  assign prot_clr_o = prot_end && mask_q[pidx_q];
  assign prot_idx_o = pidx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      bidx_q <= '0;
      pidx_q <= '0;
      mask_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_DATA;
          tmr_q  <= '0;
          bidx_q <= '0;
          pidx_q <= '0;
          mask_q <= mask_i;
        end
        ST_DATA: begin
          if (blk_end) begin
            tmr_q <= '0;
            if (bidx_q == BIW'(NBLK - 1)) st_q <= ST_PROT;
            else bidx_q <= bidx_q + 1'b1;
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_PROT: begin
          if (prot_end) begin
            tmr_q <= '0;
            if (pidx_q == PIW'(NPROT - 1)) st_q <= ST_IDLE;
            else pidx_q <= pidx_q + 1'b1;
          end else tmr_q <= tmr_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fps_array_model.sv
module fps_array_model
  import flash_seq_pkg::*;
#(
  parameter int NBLK  = 4,
  parameter int NPROT = 4
) (
  input  logic                     clk_i,
  input  logic                     por_ni,
  input  logic                     blk_clr_i,
  input  logic [$clog2(NBLK)-1:0]  blk_idx_i,
  input  logic                     prot_clr_i,
  input  logic [$clog2(NPROT)-1:0] prot_idx_i,
  input  logic [$clog2(NBLK)-1:0]  rd_addr_i,
  input  logic                     rd_ext_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_blocked_o,
  output logic [NPROT-1:0]         prot_o
);
  logic [DATA_W-1:0] mem_q [NBLK];
  logic [NPROT-1:0]  prot_q;

  // nonvolatile cells: only power-on reloads them
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      for (int k = 0; k < NBLK; k++) mem_q[k] <= init_word(k);
      prot_q <= '1;
    end else begin
      if (blk_clr_i)  mem_q[blk_idx_i]   <= '1;
      if (prot_clr_i) prot_q[prot_idx_i] <= 1'b0;
    end
  end

  assign rd_blocked_o = rd_ext_i && (&prot_q);
  assign rd_data_o    = rd_blocked_o ? '0 : mem_q[rd_addr_i];
  assign prot_o       = prot_q;
endmodule

// File: rtl/flash_prot_erase_seq.sv
module flash_prot_erase_seq
  import flash_seq_pkg::*;
#(
  parameter int NBLK     = 4,
  parameter int NPROT    = 4,
  parameter int BLK_CYC  = 3,
  parameter int PROT_CYC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    por_ni,
  input  logic                    bus_wr_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  input  logic                    sw_rst_i,
  input  logic [$clog2(NBLK)-1:0] rd_addr_i,
  input  logic                    rd_ext_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    rd_blocked_o,
  output logic                    rdy_o,
  output logic [NPROT-1:0]        prot_o
);
  localparam int BIW = $clog2(NBLK);
  localparam int PIW = $clog2(NPROT);

  logic             start, busy, blk_clr, prot_clr;
  logic [NPROT-1:0] mask;
  logic [2:0]       cnt;
  logic [BIW-1:0]   blk_idx;
  logic [PIW-1:0]   prot_idx;

  fps_cmd_decode #(.NPROT(NPROT)) u_dec (
    .clk_i, .rst_ni, .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .sw_rst_i, .busy_i(busy), .start_o(start), .mask_o(mask), .cnt_o(cnt)
  );

  fps_erase_engine #(
    .NBLK(NBLK), .NPROT(NPROT), .BLK_CYC(BLK_CYC), .PROT_CYC(PROT_CYC)
  ) u_eng (
    .clk_i, .rst_ni, .start_i(start), .mask_i(mask), .busy_o(busy),
    .blk_clr_o(blk_clr), .blk_idx_o(blk_idx),
    .prot_clr_o(prot_clr), .prot_idx_o(prot_idx)
  );

  fps_array_model #(.NBLK(NBLK), .NPROT(NPROT)) u_arr (
    .clk_i, .por_ni, .blk_clr_i(blk_clr), .blk_idx_i(blk_idx),
    .prot_clr_i(prot_clr), .prot_idx_i(prot_idx),
    .rd_addr_i, .rd_ext_i, .rd_data_o, .rd_blocked_o, .prot_o
  );

  assign rdy_o = !busy;
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int NBLK     = 4,
  parameter int NPROT    = 4,
  parameter int BLK_CYC  = 3,
  parameter int PROT_CYC = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ni,
  input logic             rdy_o,
  input logic [NPROT-1:0] prot_o,
  input logic             start,
  input logic             blk_clr,
  input logic             prot_clr,
  input logic [2:0]       cnt
);
  localparam int TOTAL = NBLK * BLK_CYC + NPROT * PROT_CYC;

  logic        pv_r, pv_p;
  logic [31:0] busy_cnt;
  logic [31:0] blk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_r     <= 1'b0;
      busy_cnt <= '0;
      blk_cnt  <= '0;
    end else begin
      pv_r     <= 1'b1;
      busy_cnt <= rdy_o ? '0 : busy_cnt + 1;
      blk_cnt  <= start ? '0 : blk_cnt + 32'(blk_clr);
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) pv_p <= 1'b0;
    else         pv_p <= 1'b1;
  end

  AST_START_DROPS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !rdy_o); // R2
  AST_IDLE_COUNTER_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> cnt == 3'd0); // R4
  AST_DATA_BEFORE_PROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_clr |-> blk_cnt == 32'(NBLK)); // R6
  AST_PROT_NEVER_RISES: assert property (@(posedge clk_i) disable iff (!por_ni)
    pv_p |-> (prot_o & ~$past(prot_o)) == '0); // R7
  AST_PROT_MOVES_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!por_ni)
    (pv_p && prot_o != $past(prot_o)) |-> !$past(rdy_o)); // R9
  AST_OP_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_r && rdy_o && !$past(rdy_o)) |-> busy_cnt == 32'(TOTAL)); // R8
endmodule

bind flash_prot_erase_seq fps_checker #(
  .NBLK(NBLK), .NPROT(NPROT), .BLK_CYC(BLK_CYC), .PROT_CYC(PROT_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .rdy_o(rdy_o), .prot_o(prot_o),
  .start(start), .blk_clr(blk_clr), .prot_clr(prot_clr), .cnt(cnt)
);

// File: tb/flash_prot_erase_seq_test.sv
module flash_prot_erase_seq_test;
  localparam int NBLK = 4, NPROT = 4, BLK_CYC = 3, PROT_CYC = 2;
  localparam int TOTAL = NBLK * BLK_CYC + NPROT * PROT_CYC;

  logic        clk = 0, rst_n = 0, por_n = 0;
  logic        wr = 0, sw_rst = 0, rd_ext = 0;
  logic [11:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [1:0]  rd_addr = 0;
  logic [15:0] rd_data;
  logic        rd_blk, rdy;
  logic [3:0]  prot;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_prot_erase_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .sw_rst_i(sw_rst), .rd_addr_i(rd_addr), .rd_ext_i(rd_ext),
    .rd_data_o(rd_data), .rd_blocked_o(rd_blk), .rdy_o(rdy), .prot_o(prot)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] ea(input int c);
    return (c == 2 || c == 5) ? 12'h2AA : 12'h555;
  endfunction
  function automatic logic [15:0] ed(input int c);
    case (c) 1, 4: return 16'hAA; 2, 5: return 16'h55; 3: return 16'h80; default: return 16'h60; endcase
  endfunction

  // called at negedge, returns at the next negedge
  task automatic bwr(input logic [11:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask
  task automatic cyc(input int c, input logic [3:0] m);
    if (c == 7) bwr(12'h123, {12'h0, m}); else bwr(ea(c), ed(c));
  endtask
  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic por_all();
    por_n = 0; rst_n = 0; step(); por_n = 1; rst_n = 1; step();
  endtask
  task automatic read_blk(input int k, input bit ext, output logic [15:0] d, output logic b);
    rd_addr = 2'(k); rd_ext = ext; #1; d = rd_data; b = rd_blk; rd_ext = 0;
  endtask
  task automatic wait_done();
    int n = 0;
    while (!rdy && n < 100) begin step(); n++; end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d; logic b;
    @(negedge clk);
    por_all();
    // R1 reset state
    chk(rdy === 1'b1, "R1 rdy", 32'(rdy), 1);
    chk(prot === 4'hF, "R1 prot", 32'(prot), 32'hF);
    for (int k = 0; k < NBLK; k++) begin
      read_blk(k, 0, d, b);
      chk(d === 16'h1000 + 16'(k), "R1 init word", 32'(d), 32'h1000 + k);
    end
    // R10 gating with all bits set
    for (int k = 0; k < NBLK; k++) begin
      read_blk(k, 1, d, b);
      chk(b === 1'b1 && d === 16'h0, "R10 blocked ext read", {15'h0, b, d}, 32'h10000);
    end

    // R2 R6 R7 R8: exhaustive sweep over masks, per-cycle expectations
    for (int m = 0; m < 16; m++) begin
      por_all();
      for (int c = 1; c <= 7; c++) cyc(c, 4'(m));
      chk(rdy === 1'b0, "R2 rdy low after 7th write", 32'(rdy), 0);
      for (int k = 1; k <= TOTAL; k++) begin
        logic [3:0] ep;
        step();
        ep = 4'hF;
        for (int i = 0; i < NPROT; i++)
          if (m[i] && k >= NBLK * BLK_CYC + (i + 1) * PROT_CYC) ep[i] = 1'b0;
        chk(prot === ep, "R7 prot progress", 32'(prot), 32'(ep));
        chk(rdy === (k >= TOTAL), "R8 rdy timing", 32'(rdy), 32'(k >= TOTAL));
        for (int bk = 0; bk < NBLK; bk++) begin
          logic [15:0] ew;
          ew = (k >= (bk + 1) * BLK_CYC) ? 16'hFFFF : 16'h1000 + 16'(bk);
          read_blk(bk, 0, d, b);
          chk(d === ew, "R6 block erase timing", 32'(d), 32'(ew));
        end
      end
      // R10 after erase: gating depends on all bits set
      read_blk(0, 1, d, b);
      chk(b === (m == 0) && d === ((m == 0) ? 16'h0 : 16'hFFFF), "R10 ext read after op",
          {15'h0, b, d}, (m == 0) ? 32'h10000 : 32'hFFFF);
    end

    // R3: bad address or data in each of cycles 1..6
    for (int n = 1; n <= 6; n++) begin
      for (int kind = 0; kind < 2; kind++) begin
        por_all();
        for (int c = 1; c < n; c++) cyc(c, 4'h0);
        if (kind == 0) bwr(ea(n) ^ 12'h001, ed(n)); else bwr(ea(n), ed(n) ^ 16'h0001);
        for (int c = n + 1; c <= 7; c++) cyc(c, 4'h0);
        step();
        chk(rdy === 1'b1, "R3 bad cycle restarts counter", 32'(rdy), 1);
        for (int c = 1; c <= 7; c++) cyc(c, 4'h0);
        chk(rdy === 1'b0, "R3 fresh sequence after bad one", 32'(rdy), 0);
        wait_done();
      end
    end

    // R4: writes during the operation are ignored
    por_all();
    for (int c = 1; c <= 7; c++) cyc(c, 4'h0);
    step();
    cyc(1, 4'h0);
    wait_done();
    for (int c = 2; c <= 7; c++) cyc(c, 4'h0);
    step();
    chk(rdy === 1'b1, "R4 busy write not counted", 32'(rdy), 1);

    // R5: software reset while busy has no effect on length or result
    por_all();
    for (int c = 1; c <= 7; c++) cyc(c, 4'h8);
    for (int k = 1; k < TOTAL; k++) begin
      if (k == 4 || k == 13) sw_rst = 1;
      step();
      sw_rst = 0;
    end
    chk(rdy === 1'b0, "R5 busy ignores sw reset (still busy)", 32'(rdy), 0);
    step();
    chk(rdy === 1'b1 && prot === 4'h7, "R5 op completes", {27'h0, rdy, prot}, 32'h17);
    // R5: idle software reset clears partial sequence
    for (int c = 1; c <= 3; c++) cyc(c, 4'h0);
    sw_rst = 1; step(); sw_rst = 0;
    for (int c = 4; c <= 7; c++) cyc(c, 4'h0);
    step();
    chk(rdy === 1'b1, "R5 idle sw reset clears counter", 32'(rdy), 1);
    // R5: sw reset wins over a same-cycle write
    for (int c = 1; c <= 6; c++) cyc(c, 4'h0);
    sw_rst = 1; cyc(7, 4'h0); sw_rst = 0;
    step();
    chk(rdy === 1'b1, "R5 sw reset beats 7th write", 32'(rdy), 1);

    // R9: hardware reset aborts and keeps partial state
    por_all();
    for (int c = 1; c <= 7; c++) cyc(c, 4'hF);
    for (int k = 1; k <= NBLK * BLK_CYC + PROT_CYC + 1; k++) step();
    rst_n = 0; #1;
    chk(rdy === 1'b1, "R9 rdy after hw reset", 32'(rdy), 1);
    chk(prot === 4'hE, "R9 partial prot kept", 32'(prot), 32'hE);
    read_blk(NBLK - 1, 0, d, b);
    chk(d === 16'hFFFF, "R9 erased data kept", 32'(d), 32'hFFFF);
    step(); rst_n = 1; step();
    for (int c = 1; c <= 7; c++) cyc(c, 4'h2);
    wait_done();
    chk(prot === 4'hC, "R9 new op after abort", 32'(prot), 32'hC);
    read_blk(0, 1, d, b);
    chk(b === 1'b0 && d === 16'hFFFF, "R10 ext read when not all set", {15'h0, b, d}, 32'hFFFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule